// File: doc/BRIEF.md
# Pulse-Width Serial Frame Transmitter

This block sends a 38-bit programming frame to a trimmable device over a single wire that carries no clock. The host supplies a 2-bit function code, a 2-bit parameter selector and an 8-bit value, then raises a start request. The block captures these fields and wraps them with a fixed start marker, a fixed separator and a fixed end marker. It then sends the frame one bit at a time, starting with the most significant bit.

Each bit is sent as one high pulse followed by a low guard gap. The width of the pulse carries the value of the bit. A short pulse means 0 and a long pulse means 1. The three widths are set in clock cycles by parameters. By default they come from a 1 µs short pulse, a 50 µs long pulse and a 10 µs gap at the configured clock rate. While a frame is in flight the block reports busy. It gives a one-cycle done strobe once the last guard gap has ended. Between frames the line rests low.

Top module: `pwfm_tx`

## Requirements
- R1: After reset, `line_o`, `busy_o` and `done_o` are all low.
- R2: The frame is 38 bits, sent in this order: start marker `1000_0000_0001`, function (2 bits), parameter (2 bits), separator `10`, value (8 bits), end marker `0111_1111_1110`. Every field is sent most significant bit first.
- R3: A 0 bit is a high pulse of exactly `CLK_MHZ*T0_US` cycles.
- R4: A 1 bit is a high pulse of exactly `CLK_MHZ*T1_US` cycles.
- R5: Every pulse, including the last one, is followed by exactly `CLK_MHZ*GAP_US` low cycles.
- R6: `busy_o` rises in the cycle after an accepted start. It stays high until the last guard gap of the frame has ended.
- R7: `done_o` is high for exactly one cycle, in the cycle right after the last gap of bit 38, and `busy_o` is low in that cycle.
- R8: A start request while busy is ignored. Changes to the field inputs while busy do not alter the frame in flight, and no second frame follows.
- R9: While no frame is in flight, `line_o` stays low.
- R10: A start request given in the done cycle is accepted, and the next frame begins in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to send one frame, sampled while idle |
| func_i | input | 2 | Function code field |
| param_i | input | 2 | Parameter selector field |
| value_i | input | 8 | Data value field |
| line_o | output | 1 | Pulse-width coded serial line |
| busy_o | output | 1 | A frame is being sent |
| done_o | output | 1 | One-cycle strobe when a frame has finished |

## Verification
Frames are sent with three kinds of field contents:
- All fields zero. This checks the fixed markers and separator on their own.
- All fields ones. This produces the most long pulses.
- Asymmetric codes (function 01, parameter 10, value 3C or A5). A swapped field or a reversed bit order shows up in the decoded frame.

Every decoded pulse width and gap is compared against its nominal cycle count. A frame is also sent with a mid-frame start and changed field inputs, which shows whether the captured frame is protected. A back-to-back pair sent from the done cycle shows whether the block returns to idle in time.

// File: rtl/pwfm_pkg.sv
package pwfm_pkg;

    // Field widths of the programming frame
    localparam int MARK_W  = 12;
    localparam int FUNC_W  = 2;
    localparam int PARAM_W = 2;
    localparam int SEP_W   = 2;
    localparam int VALUE_W = 8;
    localparam int FRAME_W = 2 * MARK_W + FUNC_W + PARAM_W + SEP_W + VALUE_W;

    // Fixed patterns
    localparam logic [MARK_W-1:0] HEAD_MARK = 12'b1000_0000_0001;
    localparam logic [MARK_W-1:0] TAIL_MARK = 12'b0111_1111_1110;
    localparam logic [SEP_W-1:0]  SEP_BITS  = 2'b10;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_MARK  = 2'd1,
        ST_SPACE = 2'd2
    } tx_state_e;

endpackage

// File: rtl/pwfm_frame_asm.sv
module pwfm_frame_asm
    import pwfm_pkg::*;
(
    input  logic [FUNC_W-1:0]  func_i,
    input  logic [PARAM_W-1:0] param_i,
    input  logic [VALUE_W-1:0] value_i,
    output logic [FRAME_W-1:0] frame_o
);

    // The bit at index FRAME_W-1 goes on the line first
    always_comb begin
        frame_o = {HEAD_MARK, func_i, param_i, SEP_BITS, value_i, TAIL_MARK};
    end

endmodule

// File: rtl/pwfm_width_sel.sv
module pwfm_width_sel #(
    parameter int SHORT_CYC = 10,
    parameter int LONG_CYC  = 500,
    parameter int CNT_W     = 9
) (
    input  logic             bit_i,
    output logic [CNT_W-1:0] load_o
);

    localparam logic [CNT_W-1:0] SHORT_LOAD = CNT_W'(SHORT_CYC - 1);
    localparam logic [CNT_W-1:0] LONG_LOAD  = CNT_W'(LONG_CYC - 1);

    // Counter load value for a high pulse; the counter counts down to zero
    always_comb begin
        load_o = bit_i ? LONG_LOAD : SHORT_LOAD;
    end

endmodule

// File: rtl/pwfm_seq.sv
module pwfm_seq
    import pwfm_pkg::*;
#(
    parameter int GAP_CYC = 100,
    parameter int CNT_W   = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [FRAME_W-1:0] frame_i,
    input  logic [CNT_W-1:0]   load_i,
    output logic               next_bit_o,
    output logic               line_o,
    output logic               busy_o,
    output logic               done_o
);

    localparam int IDX_W = $clog2(FRAME_W);
    localparam logic [IDX_W-1:0] IDX_TOP  = IDX_W'(FRAME_W - 1);
    localparam logic [CNT_W-1:0] GAP_LOAD = CNT_W'(GAP_CYC - 1);

    typedef struct packed {
        tx_state_e          st;
        logic [FRAME_W-1:0] frame;
        logic [IDX_W-1:0]   idx;
        logic [CNT_W-1:0]   cnt;
        logic               done;
    } seq_regs_t;

    localparam seq_regs_t REGS_RESET = '{
        st:    ST_IDLE,
        frame: '0,
        idx:   '0,
        cnt:   '0,
        done:  1'b0
    };

    seq_regs_t regs_q;
    seq_regs_t regs_d;

    // Bit whose pulse starts next: the first frame bit while idle, otherwise the one after idx
    always_comb begin
        if (regs_q.st == ST_IDLE) begin
            next_bit_o = frame_i[FRAME_W-1];
        end else if (regs_q.idx == '0) begin
            next_bit_o = 1'b0;
        end else begin
            next_bit_o = regs_q.frame[regs_q.idx - IDX_W'(1)];
        end
    end

    always_comb begin
        regs_d      = regs_q;
        regs_d.done = 1'b0;
        unique case (regs_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    regs_d.st    = ST_MARK;
                    regs_d.frame = frame_i;
                    regs_d.idx   = IDX_TOP;
                    regs_d.cnt   = load_i;
                end
            end
            ST_MARK: begin
                if (regs_q.cnt == '0) begin
                    regs_d.st  = ST_SPACE;
                    regs_d.cnt = GAP_LOAD;
                end else begin
                    regs_d.cnt = regs_q.cnt - CNT_W'(1);
                end
            end
            ST_SPACE: begin
                if (regs_q.cnt != '0) begin
                    regs_d.cnt = regs_q.cnt - CNT_W'(1);
                end else if (regs_q.idx == '0) begin
                    regs_d.st   = ST_IDLE;
                    regs_d.done = 1'b1;
                end else begin
                    regs_d.st  = ST_MARK;
                    regs_d.idx = regs_q.idx - IDX_W'(1);
                    regs_d.cnt = load_i;
                end
            end
            default: begin
                regs_d = REGS_RESET;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= REGS_RESET;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign line_o = (regs_q.st == ST_MARK);
    assign busy_o = (regs_q.st != ST_IDLE);
    assign done_o = regs_q.done;

    // R7: the done strobe lasts a single cycle
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R7: busy is already low when done is reported
    a_r7_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R6: busy only ends through the done path
    a_r6_busy_ends_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);

    // R5: an unfinished guard gap keeps the line low in the next cycle
    a_r5_gap_holds_low: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.st == ST_SPACE && regs_q.cnt != '0) |=> !line_o);

    // R8: the captured frame does not change while a frame is in flight
    a_r8_frame_hold: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> (!busy_o || $stable(regs_q.frame)));

    // R8: a start request in mid-pulse neither restarts nor advances the bit index
    a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.st == ST_MARK && regs_q.cnt != '0 && start_i)
        |=> (line_o && regs_q.idx == $past(regs_q.idx)));

    // R9: the line is low whenever no frame is in flight
    a_r9_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !line_o);

endmodule

// File: rtl/pwfm_tx.sv
module pwfm_tx
    import pwfm_pkg::*;
#(
    parameter int CLK_MHZ = 10,
    parameter int T0_US   = 1,
    parameter int T1_US   = 50,
    parameter int GAP_US  = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [FUNC_W-1:0]  func_i,
    input  logic [PARAM_W-1:0] param_i,
    input  logic [VALUE_W-1:0] value_i,
    output logic               line_o,
    output logic               busy_o,
    output logic               done_o
);

    localparam int T0_CYC  = CLK_MHZ * T0_US;
    localparam int T1_CYC  = CLK_MHZ * T1_US;
    localparam int GAP_CYC = CLK_MHZ * GAP_US;
    localparam int MAX_CYC = (T1_CYC > GAP_CYC) ? T1_CYC : GAP_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    logic [FRAME_W-1:0] frame_w;
    logic [CNT_W-1:0]   load_w;
    logic               next_bit_w;

    pwfm_frame_asm u_asm (
        .func_i  (func_i),
        .param_i (param_i),
        .value_i (value_i),
        .frame_o (frame_w)
    );

    pwfm_width_sel #(
        .SHORT_CYC (T0_CYC),
        .LONG_CYC  (T1_CYC),
        .CNT_W     (CNT_W)
    ) u_width (
        .bit_i  (next_bit_w),
        .load_o (load_w)
    );

    pwfm_seq #(
        .GAP_CYC (GAP_CYC),
        .CNT_W   (CNT_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .frame_i    (frame_w),
        .load_i     (load_w),
        .next_bit_o (next_bit_w),
        .line_o     (line_o),
        .busy_o     (busy_o),
        .done_o     (done_o)
    );

endmodule

// File: tb/pwfm_tx_tb_top.sv
`timescale 1ns/1ps
module pwfm_tx_tb_top;

    localparam int CLK_PERIOD = 500;       // 2 MHz
    localparam int MHZ   = 2;
    localparam int T0C   = MHZ * 1;
    localparam int T1C   = MHZ * 50;
    localparam int GAPC  = MHZ * 10;
    localparam int NBITS = 38;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [1:0] func_i = '0;
    logic [1:0] param_i = '0;
    logic [7:0] value_i = '0;
    logic       line_o, busy_o, done_o;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pwfm_tx #(.CLK_MHZ(MHZ), .T0_US(1), .T1_US(50), .GAP_US(10)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .func_i(func_i), .param_i(param_i), .value_i(value_i),
        .line_o(line_o), .busy_o(busy_o), .done_o(done_o)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog: run hung, actual=%0d expected<150000 cycles", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [NBITS-1:0] exp_frame(input logic [1:0] f, input logic [1:0] p,
                                                   input logic [7:0] v);
        return {12'b1000_0000_0001, f, p, 2'b10, v, 12'b0111_1111_1110};
    endfunction

    // Entered at a negedge with the first pulse high; leaves at the negedge where done is high.
    // When intrude is set, a start request with altered fields is raised in the middle of bit 5.
    task automatic capture(input logic [NBITS-1:0] exp, input bit intrude, input string tag);
        logic [NBITS-1:0] got = '0;
        int bad0 = 0, bad1 = 0, badg = 0, nobusy = 0;
        int w0 = T0C, w1 = T1C, wg = GAPC;
        for (int b = 0; b < NBITS; b++) begin
            int hi = 0;
            int lo = 0;
            while (line_o === 1'b1 && hi < 1000) begin
                if (busy_o !== 1'b1) nobusy++;
                if (intrude && b == 5 && hi == 1) begin
                    start_i = 1'b1; func_i = ~func_i; param_i = ~param_i; value_i = ~value_i;
                end else begin
                    start_i = 1'b0;
                end
                hi++;
                @(negedge clk);
            end
            while (line_o === 1'b0 && done_o !== 1'b1 && lo < 1000) begin
                if (busy_o !== 1'b1) nobusy++;
                lo++;
                @(negedge clk);
            end
            got[NBITS-1-b] = (hi > (T0C + T1C) / 2);
            if (got[NBITS-1-b] && hi != T1C) begin bad1++; w1 = hi; end
            if (!got[NBITS-1-b] && hi != T0C) begin bad0++; w0 = hi; end
            if (lo != GAPC) begin badg++; wg = lo; end
        end
        chk(got == exp, {"R2 frame content ", tag}, got, exp);
        chk(bad0 == 0, {"R3 zero pulse width ", tag}, w0, T0C);
        chk(bad1 == 0, {"R4 one pulse width ", tag}, w1, T1C);
        chk(badg == 0, {"R5 gap width ", tag}, wg, GAPC);
        chk(nobusy == 0, {"R6 busy during frame ", tag}, nobusy, 0);
        chk(done_o === 1'b1 && busy_o === 1'b0, {"R7 done with busy low ", tag},
            {done_o, busy_o}, 2'b10);
    endtask

    task automatic kick(input logic [1:0] f, input logic [1:0] p, input logic [7:0] v);
        func_i = f; param_i = p; value_i = v; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic quiet_after(input int n, input string tag);
        int hits = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (line_o !== 1'b0 || busy_o !== 1'b0 || done_o !== 1'b0) hits++;
        end
        chk(hits == 0, {"R9 line idle low ", tag}, hits, 0);
    endtask

    task automatic t_reset();
        chk(line_o === 1'b0 && busy_o === 1'b0 && done_o === 1'b0, "R1 reset outputs",
            {line_o, busy_o, done_o}, 3'b000);
        quiet_after(20, "before first start");
    endtask

    task automatic t_frame(input logic [1:0] f, input logic [1:0] p, input logic [7:0] v,
                           input string tag);
        kick(f, p, v);
        chk(line_o === 1'b1 && busy_o === 1'b1, {"R6 busy after start ", tag},
            {line_o, busy_o}, 2'b11);
        capture(exp_frame(f, p, v), 1'b0, tag);
        @(negedge clk);
        chk(done_o === 1'b0, {"R7 done single cycle ", tag}, done_o, 0);
        quiet_after(30, tag);
    endtask

    task automatic t_ignore();
        kick(2'b01, 2'b10, 8'hA5);
        capture(exp_frame(2'b01, 2'b10, 8'hA5), 1'b1, "intrude");
        start_i = 1'b0;
        // R8: no second frame starts from the ignored request
        quiet_after(300, "R8 no restart");
    endtask

    task automatic t_back2back();
        kick(2'b11, 2'b00, 8'h0F);
        capture(exp_frame(2'b11, 2'b00, 8'h0F), 1'b0, "b2b first");
        func_i = 2'b00; param_i = 2'b11; value_i = 8'hF0; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(line_o === 1'b1 && busy_o === 1'b1, "R10 start in done cycle accepted",
            {line_o, busy_o}, 2'b11);
        capture(exp_frame(2'b00, 2'b11, 8'hF0), 1'b0, "R10 second");
        quiet_after(30, "after b2b");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_frame(2'b00, 2'b00, 8'h00, "zeros");
        t_frame(2'b11, 2'b11, 8'hFF, "ones");
        t_frame(2'b01, 2'b10, 8'h3C, "asym");
        t_ignore();
        t_back2back();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule